// File: doc/BRIEF.md
# Prediction-Error Distribution Comparator with Majority Vote

This block decides whether a window of observed prediction errors follows the same distribution as a set of stored reference windows. Each signed fixed-point error is compared against a fixed list of ascending bin edges. The resulting 0/1 vectors are summed into a cumulative histogram of the test window, expressed in the reference bins.

When the window closes, the block walks every stored reference cumulative histogram one bin per cycle. It keeps a running maximum of the absolute bin-wise difference, which equals the window size times the two-sample Kolmogorov-Smirnov distance. No division, square root or sorting is needed. Each reference whose maximum exceeds a pre-scaled threshold casts one vote, and the window is declared abnormal when more than half of the references vote.

Bin edges, reference histograms and the threshold are loaded through a single register-write port before use. With one reference configured, the block performs a single plain test.

Top module: `ped_ks_detector`

## Requirements
- R1: For each accepted error x and each bin b, the bin contributes 1 to the test histogram exactly when the signed edge of bin b is strictly greater than x. An error equal to an edge contributes 0 for that bin.
- R2: Errors are accepted only in cycles where `err_valid` is high while a window is open. The error carrying `err_last` closes the window. Errors presented after the window closes, and before the next `win_start`, have no effect on any result.
- R3: `win_start` opens a new window and clears the histogram, the running maxima and the vote count. A window of N_WIN samples (default 16) that all fall below every edge gives a count of N_WIN in every bin, with no wrap.
- R4: For each reference r, the distance is the maximum over bins of |test[b] - ref[r][b]|. `max_diff` reports the largest distance over all references.
- R5: A reference votes only when its distance is strictly greater than the threshold. A distance equal to the threshold does not vote.
- R6: `vote_cnt` is the number of voting references. `abnormal` is 1 exactly when 2*vote_cnt > NREF (default 20): with 20 references, 10 votes give 0 and 11 give 1.
- R7: `done` is high for exactly one cycle, NREF*NBINS clock edges after the edge that accepts the closing error. `abnormal`, `vote_cnt` and `max_diff` change only in that cycle and then hold.
- R8: Writes with `cfg_we` high use these addresses. Address b (0..NBINS-1) holds the signed edge of bin b, taken from all of `cfg_wdata`. Address NBINS + r*NBINS + b holds ref[r][b]. Address NBINS*(NREF+1) holds the threshold. Histogram and threshold values are taken from the low CW bits of `cfg_wdata`.
- R9: After reset, `done`, `abnormal`, `vote_cnt` and `max_diff` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| win_start | input | 1 | Opens a new test window |
| err_valid | input | 1 | Error sample valid |
| err_last | input | 1 | Marks the last sample of the window |
| err_data | input | DW | Signed prediction error |
| done | output | 1 | One-cycle completion pulse |
| abnormal | output | 1 | Majority verdict |
| vote_cnt | output | VW | Number of references above threshold |
| max_diff | output | CW | Largest scaled distance over all references |

## Verification
The checker relies on two properties of the inputs: a window never carries more than N_WIN accepted samples, and the bin edges are loaded in ascending order. Under those conditions the histogram entries stay within N_WIN and are non-decreasing across bins. The stimulus loads strictly ascending edges once and never sends a window longer than N_WIN. It probes strict edge equality, the threshold tie, and the 10-versus-11 vote split. It also sends samples after the window closes and restarts a window partway through.

// File: rtl/ks_pkg.sv
package ks_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_COLLECT = 2'd1,
      ST_SCAN = 2'd2
   } ks_state_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ks_edge_cmp.sv
module ks_edge_cmp #(
   parameter int DW = 12,
   parameter int NBINS = 8
) (
   input  logic signed [DW-1:0]   sample_i,
   input  logic [NBINS*DW-1:0]    edges_i,
   output logic [NBINS-1:0]       below_o
);
   for (genvar b = 0; b < NBINS; b++) begin : g_bin
      assign below_o[b] = $signed(edges_i[b*DW +: DW]) > sample_i;
   end
endmodule

// File: rtl/ks_cum_acc.sv
module ks_cum_acc #(
   parameter int NBINS = 8,
   parameter int CW = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 add_i,
   input  logic [NBINS-1:0]     bits_i,
   output logic [NBINS*CW-1:0]  acc_o
);
   for (genvar b = 0; b < NBINS; b++) begin : g_cell
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else if (clr_i) cnt_q <= '0;
         else if (add_i && bits_i[b]) cnt_q <= cnt_q + CW'(1);
      end
      assign acc_o[b*CW +: CW] = cnt_q;
   end
endmodule

// File: rtl/ks_max_scan.sv
module ks_max_scan #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   input  logic          first_i,
   input  logic [CW-1:0] test_i,
   input  logic [CW-1:0] ref_i,
   output logic [CW-1:0] new_max_o
);
   logic signed [CW:0] diff;
   logic [CW-1:0]      mag;
   logic [CW-1:0]      base;
   logic [CW-1:0]      cur_q;

   always_comb begin
      diff = $signed({1'b0, test_i}) - $signed({1'b0, ref_i});
      mag = diff[CW] ? CW'(-diff) : diff[CW-1:0];
      base = first_i ? '0 : cur_q;
      new_max_o = (mag > base) ? mag : base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else if (clr_i) cur_q <= '0;
      else if (step_i) cur_q <= new_max_o;
   end
endmodule

// File: rtl/ped_ks_detector.sv
module ped_ks_detector
   import ks_pkg::*;
#(
   parameter int DW = 12,
   parameter int NBINS = 8,
   parameter int N_WIN = 16,
   parameter int NREF = 20,
   localparam int CW = $clog2(N_WIN + 1),
   localparam int NREG = NBINS * (NREF + 1) + 1,
   localparam int AW = $clog2(NREG),
   localparam int VW = $clog2(NREF + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [DW-1:0]        cfg_wdata,
   input  logic                 win_start,
   input  logic                 err_valid,
   input  logic                 err_last,
   input  logic signed [DW-1:0] err_data,
   output logic                 done,
   output logic                 abnormal,
   output logic [VW-1:0]        vote_cnt,
   output logic [CW-1:0]        max_diff
);
   localparam int BW = cnt_bits(NBINS);
   localparam int RW = cnt_bits(NREF);
   localparam int NCELL = NREF * NBINS;
   localparam int IW = cnt_bits(NCELL);
   localparam int THR_ADDR = NBINS * (NREF + 1);

   if (NBINS < 2) begin : g_chk_bins
      $error("NBINS must be at least 2");
   end
   if (NREF < 1) begin : g_chk_ref
      $error("NREF must be at least 1");
   end
   if (N_WIN < 1) begin : g_chk_win
      $error("N_WIN must be at least 1");
   end
   if (CW > DW) begin : g_chk_width
      $error("DW must hold a histogram count");
   end

   // configuration storage
   logic [NBINS*DW-1:0] edges_q;
   logic [CW-1:0]       ref_q [NCELL];
   logic [CW-1:0]       thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges_q <= '0;
         thr_q <= '0;
         for (int i = 0; i < NCELL; i++) ref_q[i] <= '0;
      end else if (cfg_we) begin
         for (int b = 0; b < NBINS; b++)
            if (cfg_addr == AW'(b)) edges_q[b*DW +: DW] <= cfg_wdata;
         for (int i = 0; i < NCELL; i++)
            if (cfg_addr == AW'(NBINS + i)) ref_q[i] <= cfg_wdata[CW-1:0];
         if (cfg_addr == AW'(THR_ADDR)) thr_q <= cfg_wdata[CW-1:0];
      end
   end

   // control state
   ks_state_e      state_q;
   logic [BW-1:0]  bin_q;
   logic [RW-1:0]  ref_sel_q;
   logic [VW-1:0]  vcnt_q;
   logic [CW-1:0]  allmax_q;

   logic [NBINS-1:0]    below;
   logic [NBINS*CW-1:0] acc_flat;
   logic                take;
   logic                scanning;
   logic [IW-1:0]       cell_idx;
   logic [CW-1:0]       test_val;
   logic [CW-1:0]       ref_val;
   logic [CW-1:0]       ref_max;
   logic                last_bin;
   logic                last_ref;
   logic                over;
   logic [VW-1:0]       vcnt_next;
   logic [CW-1:0]       allmax_next;

   assign take = (state_q == ST_COLLECT) && err_valid && !win_start;
   assign scanning = (state_q == ST_SCAN) && !win_start;

   ks_edge_cmp #(.DW(DW), .NBINS(NBINS)) u_cmp (
      .sample_i(err_data),
      .edges_i (edges_q),
      .below_o (below)
   );

   ks_cum_acc #(.NBINS(NBINS), .CW(CW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (win_start),
      .add_i (take),
      .bits_i(below),
      .acc_o (acc_flat)
   );

   always_comb begin
      cell_idx = IW'(int'(ref_sel_q) * NBINS + int'(bin_q));
      test_val = acc_flat[bin_q*CW +: CW];
      ref_val = ref_q[cell_idx];
   end

   ks_max_scan #(.CW(CW)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (win_start),
      .step_i   (scanning),
      .first_i  (bin_q == '0),
      .test_i   (test_val),
      .ref_i    (ref_val),
      .new_max_o(ref_max)
   );

   always_comb begin
      last_bin = (bin_q == BW'(NBINS - 1));
      last_ref = (ref_sel_q == RW'(NREF - 1));
      over = ref_max > thr_q;
      vcnt_next = vcnt_q + VW'(over);
      allmax_next = (ref_max > allmax_q) ? ref_max : allmax_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bin_q <= '0;
         ref_sel_q <= '0;
         vcnt_q <= '0;
         allmax_q <= '0;
         done <= 1'b0;
         abnormal <= 1'b0;
         vote_cnt <= '0;
         max_diff <= '0;
      end else begin
         done <= 1'b0;
         if (win_start) begin
            state_q <= ST_COLLECT;
            bin_q <= '0;
            ref_sel_q <= '0;
            vcnt_q <= '0;
            allmax_q <= '0;
         end else begin
            case (state_q)
               ST_COLLECT: begin
                  if (err_valid && err_last) begin
                     state_q <= ST_SCAN;
                     bin_q <= '0;
                     ref_sel_q <= '0;
                  end
               end
               ST_SCAN: begin
                  if (!last_bin) begin
                     bin_q <= bin_q + BW'(1);
                  end else begin
                     bin_q <= '0;
                     vcnt_q <= vcnt_next;
                     allmax_q <= allmax_next;
                     if (last_ref) begin
                        state_q <= ST_IDLE;
                        done <= 1'b1;
                        vote_cnt <= vcnt_next;
                        max_diff <= allmax_next;
                        abnormal <= ({vcnt_next, 1'b0} > (VW+1)'(NREF));
                     end else begin
                        ref_sel_q <= ref_sel_q + RW'(1);
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/ped_ks_detector_chk.sv
module ped_ks_detector_chk #(
   parameter int NBINS = 8,
   parameter int N_WIN = 16,
   parameter int NREF = 20,
   parameter int CW = 5,
   parameter int VW = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                done,
   input logic                abnormal,
   input logic [VW-1:0]       vote_cnt,
   input logic [CW-1:0]       max_diff,
   input logic [NBINS*CW-1:0] acc_flat
);
   logic acc_in_range;
   logic acc_ordered;

   always_comb begin
      acc_in_range = 1'b1;
      acc_ordered = 1'b1;
      for (int b = 0; b < NBINS; b++) begin
         if (int'(acc_flat[b*CW +: CW]) > N_WIN) acc_in_range = 1'b0;
         if (b > 0 && acc_flat[b*CW +: CW] < acc_flat[(b-1)*CW +: CW])
            acc_ordered = 1'b0;
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_in_range);

   assert_cum_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ordered);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(abnormal) && $stable(vote_cnt) && $stable(max_diff)));

   assert_majority_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (abnormal == (2 * int'(vote_cnt) > NREF)));

   assert_vote_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(vote_cnt) <= NREF);

   assert_dist_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(max_diff) <= N_WIN);
endmodule

bind ped_ks_detector ped_ks_detector_chk #(
   .NBINS(NBINS),
   .N_WIN(N_WIN),
   .NREF(NREF),
   .CW(CW),
   .VW(VW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .abnormal(abnormal),
   .vote_cnt(vote_cnt),
   .max_diff(max_diff),
   .acc_flat(acc_flat)
);

// File: tb/ped_ks_detector_tb.sv
module ped_ks_detector_tb;
   localparam int CLK_P = 10;
   localparam int DW = 12;
   localparam int NBINS = 8;
   localparam int N_WIN = 16;
   localparam int NREF = 20;
   localparam int CW = $clog2(N_WIN + 1);
   localparam int AW = $clog2(NBINS * (NREF + 1) + 1);
   localparam int VW = $clog2(NREF + 1);
   localparam int THR_ADDR = NBINS * (NREF + 1);

   // base, step, count, send extra samples after close
   localparam int VEC [6][4] = '{
      '{-100,  10, 16, 0},
      '{ -64,  16, 16, 0},
      '{1000,   0, 16, 0},
      '{-1000,  0, 16, 1},
      '{   5,  -7, 16, 1},
      '{ -20,   3,  9, 0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic win_start = 1'b0;
   logic err_valid = 1'b0;
   logic err_last = 1'b0;
   logic signed [DW-1:0] err_data = '0;
   logic done;
   logic abnormal;
   logic [VW-1:0] vote_cnt;
   logic [CW-1:0] max_diff;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 0;

   int edges [NBINS];
   int refc [NREF][NBINS];
   int thr;
   int win [N_WIN];
   int nwin;
   int exp_votes, exp_max, exp_abn;

   always #(CLK_P/2) clk = ~clk;

   ped_ks_detector #(.DW(DW), .NBINS(NBINS), .N_WIN(N_WIN), .NREF(NREF)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .win_start(win_start), .err_valid(err_valid),
      .err_last(err_last), .err_data(err_data), .done(done),
      .abnormal(abnormal), .vote_cnt(vote_cnt), .max_diff(max_diff)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = AW'(addr);
      cfg_wdata = DW'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_ref(input int r, input int b, input int v);
      refc[r][b] = v;
      wr(NBINS + r * NBINS + b, v);  // R8 address map
   endtask

   task automatic set_thr(input int v);
      thr = v;
      wr(THR_ADDR, v);  // R8 threshold address
   endtask

   function automatic void model();
      int m, c, d;
      exp_votes = 0;
      exp_max = 0;
      for (int r = 0; r < NREF; r++) begin
         m = 0;
         for (int b = 0; b < NBINS; b++) begin
            c = 0;
            for (int i = 0; i < nwin; i++) if (edges[b] > win[i]) c++;
            d = c - refc[r][b];
            if (d < 0) d = -d;
            if (d > m) m = d;
         end
         if (m > thr) exp_votes++;
         if (m > exp_max) exp_max = m;
      end
      exp_abn = (2 * exp_votes > NREF) ? 1 : 0;
   endfunction

   task automatic run_win(input int base, input int step, input int cnt,
                          input int junk, input string tag);
      int got;
      int a0, v0, m0;
      nwin = cnt;
      for (int i = 0; i < cnt; i++) win[i] = base + step * i;
      @(negedge clk);
      win_start = 1'b1;
      @(negedge clk);
      win_start = 1'b0;
      for (int i = 0; i < cnt; i++) begin
         err_valid = 1'b1;
         err_data = DW'(win[i]);
         err_last = (i == cnt - 1);
         @(negedge clk);
      end
      err_valid = 1'b0;
      err_last = 1'b0;
      if (junk != 0) begin
         for (int k = 0; k < 4; k++) begin
            err_valid = 1'b1;
            err_last = k[0];
            err_data = DW'(-2000);
            @(negedge clk);
         end
         err_valid = 1'b0;
         err_last = 1'b0;
      end
      got = 0;
      for (int k = 0; k < 2000; k++) begin
         if (done) begin
            got = 1;
            break;
         end
         @(negedge clk);
      end
      model();
      chk(got == 1, {"R7 done seen ", tag}, got, 1);
      chk(int'(vote_cnt) == exp_votes, {"R5 votes ", tag}, int'(vote_cnt), exp_votes);
      chk(int'(max_diff) == exp_max, {"R4 max_diff ", tag}, int'(max_diff), exp_max);
      chk(int'(abnormal) == exp_abn, {"R6 abnormal ", tag}, int'(abnormal), exp_abn);
      a0 = int'(abnormal);
      v0 = int'(vote_cnt);
      m0 = int'(max_diff);
      @(negedge clk);
      chk(done == 1'b0, {"R7 single pulse ", tag}, int'(done), 0);
      chk(int'(abnormal) == a0 && int'(vote_cnt) == v0 && int'(max_diff) == m0,
          {"R7 hold ", tag}, int'(max_diff), m0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      edges = '{-64, -32, -16, 0, 16, 32, 64, 128};
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(done == 1'b0, "R9 done", int'(done), 0);
      chk(abnormal == 1'b0, "R9 abnormal", int'(abnormal), 0);
      chk(vote_cnt == '0, "R9 vote_cnt", int'(vote_cnt), 0);
      chk(max_diff == '0, "R9 max_diff", int'(max_diff), 0);
      rst_n = 1'b1;

      // R8 load edges, references, threshold
      for (int b = 0; b < NBINS; b++) wr(b, edges[b]);
      for (int r = 0; r < NREF; r++)
         for (int b = 0; b < NBINS; b++) begin
            int v = 2 * (b + 1) + (r % 5) - 2;
            if (v < 0) v = 0;
            if (v > N_WIN) v = N_WIN;
            set_ref(r, b, v);
         end
      set_thr(6);

      // vector table: R1 edge hits (row 1), R3 full bins (row 3), R2 late samples
      for (int t = 0; t < 6; t++)
         run_win(VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3], $sformatf("vec%0d", t));

      // R5 threshold tie: distance equal to threshold does not vote
      nwin = 16;
      for (int i = 0; i < 16; i++) win[i] = -100 + 10 * i;
      model();
      set_thr(exp_max);
      run_win(-100, 10, 16, 0, "R5 tie");
      chk(vote_cnt == '0, "R5 tie no vote", int'(vote_cnt), 0);
      set_thr(exp_max - 1);
      run_win(-100, 10, 16, 0, "R5 tie minus one");
      chk(vote_cnt != '0, "R5 above tie votes", int'(vote_cnt), 1);
      set_thr(6);

      // R6 majority boundary: 10 of 20 then 11 of 20
      for (int r = 0; r < NREF; r++)
         for (int b = 0; b < NBINS; b++) set_ref(r, b, (r < 10) ? 16 : 0);
      run_win(1000, 0, 16, 0, "R6 ten");
      chk(int'(vote_cnt) == 10, "R6 ten votes", int'(vote_cnt), 10);
      chk(abnormal == 1'b0, "R6 ten not abnormal", int'(abnormal), 0);
      for (int b = 0; b < NBINS; b++) set_ref(10, b, 16);
      run_win(1000, 0, 16, 0, "R6 eleven");
      chk(int'(vote_cnt) == 11, "R6 eleven votes", int'(vote_cnt), 11);
      chk(abnormal == 1'b1, "R6 eleven abnormal", int'(abnormal), 1);

      // R3 restart mid-window clears the partial histogram
      @(negedge clk);
      win_start = 1'b1;
      @(negedge clk);
      win_start = 1'b0;
      for (int i = 0; i < 5; i++) begin
         err_valid = 1'b1;
         err_data = DW'(-1000);
         @(negedge clk);
      end
      err_valid = 1'b0;
      run_win(1000, 0, 16, 0, "R3 restart");
      chk(int'(max_diff) == 16, "R3 restart max", int'(max_diff), 16);

      // R2 samples while idle do not disturb held results
      for (int k = 0; k < 5; k++) begin
         err_valid = 1'b1;
         err_last = 1'b1;
         err_data = DW'(-1000);
         @(negedge clk);
      end
      err_valid = 1'b0;
      err_last = 1'b0;
      chk(int'(vote_cnt) == 11 && done == 1'b0, "R2 idle samples ignored",
          int'(vote_cnt), 11);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule